// File: doc/BRIEF.md
# Shared-Memory Mailbox Interrupt Handshake

This block sits beside a shared RAM that a host processor and a local processor both reach through a common arbiter. It watches each shared cycle as it finishes. From the cycle's owner, region, offset and direction it decides whether the cycle touched one of two mailbox words at the bottom of the lower RAM block. If it did, the block raises or drops an interrupt in one direction or the other. The RAM itself still stores the mailbox data. This block only derives interrupt state from the accesses.

The two words work as follows. A host write to the command word flags the local CPU, and the local CPU drops that flag by reading the word back. A local write to the condition word posts a request toward the host, and the host drops it by reading the condition word. The host request reaches the pins only while the host has enabled it through a hardware register. A 2-bit level setting then routes it onto one of four host interrupt lines, which stand for priority levels 3 to 6.

Top module: `mbox_irq_top`

## Requirements
- R1: While `rstN` is low, and after it rises, the command flag, the host request flag and the host enable flag are all clear. `localIrq` is 0 and every bit of `hostIrq` is 0.
- R2: A completed host write (`cycHost`=1, `cycWrite`=1) to the lower region (`cycRegion`=2'b01) at offset 0 sets `localIrq` to 1 after the clock edge on which `cycDone` is sampled high.
- R3: A completed local read (`cycHost`=0, `cycWrite`=0) of lower-region offset 0 clears `localIrq` after that edge.
- R4: A completed local write to lower-region offset 1 sets the host request flag.
- R5: A completed host read of lower-region offset 1 clears the host request flag, so every `hostIrq` bit is 0 after that edge.
- R6: A `hostIrq` bit is 1 only while the host request flag and the host enable flag are both set.
- R7: While the host interrupt is active, `hostIrq` bit `lvlSel` is 1 and the other bits are 0. Bit 0 stands for level 3 and bit 3 for level 6. A change of `lvlSel` moves the active line without any cycle.
- R8: A completed host write to the hardware-register region (`cycRegion`=2'b00) at offset 1 loads the enable flag from `cycWdata`. A local write to that register does not change the enable flag.
- R9: A cycle changes no flag if its owner, direction, region or offset differs from those named in R2 to R5 and R8. This covers a local write to offset 0, a host read of offset 0, a host write to offset 1, and upper-region (2'b10) accesses.
- R10: No flag changes on an edge where `cycDone` is 0, whatever the other cycle inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the shared-memory controller |
| rstN | input | 1 | Active-low asynchronous card reset |
| cycDone | input | 1 | One-clock pulse marking the end of a completed shared cycle |
| cycHost | input | 1 | Owner of the finishing cycle: 1 host, 0 local CPU |
| cycRegion | input | 2 | Region of the cycle: 00 hardware registers, 01 lower RAM, 10 upper RAM, 11 unused |
| cycOffset | input | 13 | Word offset within the region |
| cycWrite | input | 1 | Direction of the cycle: 1 write, 0 read |
| cycWdata | input | 1 | Data bit 0 of a write, used by the enable register |
| lvlSel | input | 2 | Host interrupt level setting, 0 selects level 3 up to 3 selects level 6 |
| localIrq | output | 1 | Active-high interrupt to the local CPU (command pending) |
| hostIrq | output | 4 | Active-high host interrupt lines for levels 3 to 6 |

## Verification
The bench applies near-miss cycles that match a mailbox access in every field except one, such as wrong owner, wrong direction, wrong region or wrong offset. A decoder that ignores one field would set or clear a flag on such a cycle. It checks that disabling the host enable hides a posted request without losing it, so re-enabling brings the line back. A design that cleared the request on disable would fail that check. It holds qualifying inputs with `cycDone` low for several edges, which catches a flag that updates mid-cycle. It also moves `lvlSel` with no cycle, which exposes a latched level or a decode that drives two lines. A local write to the enable register and a reset taken with everything set complete the set.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    RGN_HWREG = 2'b00,
    RGN_LOWER = 2'b01,
    RGN_UPPER = 2'b10,
    RGN_NONE  = 2'b11
  } region_e;

  // Strobes passed from decode control to the flag datapath
  typedef struct packed {
    logic setCmd;
    logic clrCmd;
    logic setReq;
    logic clrReq;
    logic loadEn;
    logic enVal;
  } strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int OFF_W    = 13,
  parameter int CMD_OFF  = 0,
  parameter int COND_OFF = 1,
  parameter int EN_REG   = 1
) (
  input  logic             cycDone,
  input  logic             cycHost,
  input  logic [1:0]       cycRegion,
  input  logic [OFF_W-1:0] cycOffset,
  input  logic             cycWrite,
  input  logic             cycWdata,
  output strobe_t          strobes
);

  localparam logic [OFF_W-1:0] CmdOff  = OFF_W'(CMD_OFF);
  localparam logic [OFF_W-1:0] CondOff = OFF_W'(COND_OFF);
  localparam logic [OFF_W-1:0] EnOff   = OFF_W'(EN_REG);

  region_e region;
  logic    lowerHit;
  logic    regHit;
  logic    atCmd;
  logic    atCond;
  logic    atEn;

  always_comb begin
    region   = region_e'(cycRegion);
    lowerHit = cycDone && (region == RGN_LOWER);
    regHit   = cycDone && (region == RGN_HWREG);
    atCmd    = (cycOffset == CmdOff);
    atCond   = (cycOffset == CondOff);
    atEn     = (cycOffset == EnOff);

    strobes        = '0;
    strobes.setCmd = lowerHit && atCmd  &&  cycHost &&  cycWrite;
    strobes.clrCmd = lowerHit && atCmd  && !cycHost && !cycWrite;
    strobes.setReq = lowerHit && atCond && !cycHost &&  cycWrite;
    strobes.clrReq = lowerHit && atCond &&  cycHost && !cycWrite;
    strobes.loadEn = regHit   && atEn   &&  cycHost &&  cycWrite;
    strobes.enVal  = cycWdata;
  end

endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LVL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [LVL_W-1:0]     lvlSel,
  output logic                 cmdFlag,
  output logic                 reqFlag,
  output logic                 enFlag,
  output logic [NUM_LINES-1:0] hostIrq
);

  logic irqActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdFlag <= 1'b0;
      reqFlag <= 1'b0;
      enFlag  <= 1'b0;
    end else begin
      if (strobes.setCmd)      cmdFlag <= 1'b1;
      else if (strobes.clrCmd) cmdFlag <= 1'b0;

      if (strobes.setReq)      reqFlag <= 1'b1;
      else if (strobes.clrReq) reqFlag <= 1'b0;

      if (strobes.loadEn)      enFlag  <= strobes.enVal;
    end
  end

  assign irqActive = enFlag && reqFlag;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign hostIrq[i] = irqActive && (lvlSel == LVL_W'(i));
  end

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
  import mbox_pkg::*;
#(
  parameter int OFF_W     = 13,
  parameter int NUM_LINES = 4,
  parameter int LVL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycDone,
  input  logic                 cycHost,
  input  logic [1:0]           cycRegion,
  input  logic [OFF_W-1:0]     cycOffset,
  input  logic                 cycWrite,
  input  logic                 cycWdata,
  input  logic [LVL_W-1:0]     lvlSel,
  output logic                 localIrq,
  output logic [NUM_LINES-1:0] hostIrq
);

  strobe_t strobes;
  logic    cmdFlag;
  logic    reqFlag;
  logic    enFlag;

  mbox_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .cycDone   (cycDone),
    .cycHost   (cycHost),
    .cycRegion (cycRegion),
    .cycOffset (cycOffset),
    .cycWrite  (cycWrite),
    .cycWdata  (cycWdata),
    .strobes   (strobes)
  );

  mbox_dp #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lvlSel  (lvlSel),
    .cmdFlag (cmdFlag),
    .reqFlag (reqFlag),
    .enFlag  (enFlag),
    .hostIrq (hostIrq)
  );

  assign localIrq = cmdFlag;

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int OFF_W     = 13,
  parameter int NUM_LINES = 4,
  parameter int LVL_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cycDone,
  input logic                 cycHost,
  input logic [1:0]           cycRegion,
  input logic [OFF_W-1:0]     cycOffset,
  input logic                 cycWrite,
  input logic [LVL_W-1:0]     lvlSel,
  input logic                 localIrq,
  input logic [NUM_LINES-1:0] hostIrq,
  input logic                 reqFlag,
  input logic                 enFlag
);

  logic lowerCmd;
  logic lowerCond;
  assign lowerCmd  = cycDone && cycRegion == 2'b01 && cycOffset == '0;
  assign lowerCond = cycDone && cycRegion == 2'b01 && cycOffset == OFF_W'(1);

  assert_cmd_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lowerCmd && cycHost && cycWrite) |=> localIrq);

  assert_cmd_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lowerCmd && !cycHost && !cycWrite) |=> !localIrq);

  assert_req_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lowerCond && cycHost && !cycWrite) |=> (hostIrq == '0));

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> (enFlag && reqFlag));

  assert_one_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hostIrq));

  assert_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> hostIrq[lvlSel]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cycDone |=> ($stable(localIrq) && $stable(reqFlag) && $stable(enFlag)));

endmodule

bind mbox_irq_top mbox_checker #(
  .OFF_W(OFF_W), .NUM_LINES(NUM_LINES), .LVL_W(LVL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycDone   (cycDone),
  .cycHost   (cycHost),
  .cycRegion (cycRegion),
  .cycOffset (cycOffset),
  .cycWrite  (cycWrite),
  .lvlSel    (lvlSel),
  .localIrq  (localIrq),
  .hostIrq   (hostIrq),
  .reqFlag   (reqFlag),
  .enFlag    (enFlag)
);

// File: tb/tb_mbox_irq_top.sv
module tb_mbox_irq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycDone = 1'b0;
  logic        cycHost = 1'b0;
  logic [1:0]  cycRegion = 2'b11;
  logic [12:0] cycOffset = '0;
  logic        cycWrite = 1'b0;
  logic        cycWdata = 1'b0;
  logic [1:0]  lvlSel = 2'd0;
  logic        localIrq;
  logic [3:0]  hostIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbox_irq_top dut (
    .clk(clk), .rstN(rstN), .cycDone(cycDone), .cycHost(cycHost),
    .cycRegion(cycRegion), .cycOffset(cycOffset), .cycWrite(cycWrite),
    .cycWdata(cycWdata), .lvlSel(lvlSel), .localIrq(localIrq), .hostIrq(hostIrq)
  );

  // Entry: host, region[2], offset[4], write, wdata, lvl[2], expLocal, expHost[4]
  localparam int NVEC = 14;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 2'b01, 4'd0, 1'b1, 1'b0, 2'd0, 1'b1, 4'b0000}, // R2 host write cmd
    {1'b0, 2'b01, 4'd0, 1'b1, 1'b0, 2'd0, 1'b1, 4'b0000}, // R9 local write cmd
    {1'b0, 2'b01, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000}, // R3 local read cmd
    {1'b1, 2'b01, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000}, // R9 host read cmd
    {1'b0, 2'b01, 4'd1, 1'b1, 1'b0, 2'd0, 1'b0, 4'b0000}, // R4 R6 request, not enabled
    {1'b1, 2'b00, 4'd1, 1'b1, 1'b1, 2'd0, 1'b0, 4'b0001}, // R8 enable, level 3
    {1'b0, 2'b00, 4'd1, 1'b1, 1'b0, 2'd0, 1'b0, 4'b0001}, // R8 local write ignored
    {1'b1, 2'b10, 4'd1, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0001}, // R9 upper region read
    {1'b1, 2'b01, 4'd1, 1'b0, 1'b0, 2'd2, 1'b0, 4'b0000}, // R5 host read clears
    {1'b0, 2'b01, 4'd1, 1'b1, 1'b0, 2'd2, 1'b0, 4'b0100}, // R4 R7 level 5
    {1'b1, 2'b01, 4'd2, 1'b1, 1'b0, 2'd3, 1'b0, 4'b1000}, // R9 R7 offset 2, level 6
    {1'b1, 2'b00, 4'd1, 1'b1, 1'b0, 2'd3, 1'b0, 4'b0000}, // R8 R6 disable hides
    {1'b1, 2'b00, 4'd1, 1'b1, 1'b1, 2'd1, 1'b0, 4'b0010}, // R6 request kept, level 4
    {1'b1, 2'b01, 4'd1, 1'b1, 1'b0, 2'd1, 1'b0, 4'b0010}  // R9 host write cond
  };

  task automatic check(input string tag, input logic expL, input logic [3:0] expH);
    checks++;
    if (localIrq !== expL || hostIrq !== expH) begin
      errors++;
      $display("FAIL %s: localIrq=%b hostIrq=%b expected localIrq=%b hostIrq=%b",
               tag, localIrq, hostIrq, expL, expH);
    end
  endtask

  task automatic runCycle(input logic host, input logic [1:0] rgn, input logic [12:0] off,
                          input logic wr, input logic wd);
    @(negedge clk);
    cycHost = host; cycRegion = rgn; cycOffset = off; cycWrite = wr; cycWdata = wd;
    cycDone = 1'b1;
    @(negedge clk);
    cycDone = 1'b0;
    cycRegion = 2'b11;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      lvlSel = VEC[i][6:5];
      runCycle(VEC[i][15], VEC[i][14:13], 13'(VEC[i][12:9]), VEC[i][8], VEC[i][7]);
      check($sformatf("table entry %0d", i), VEC[i][4], VEC[i][3:0]);
    end

    // R7: level moves without a cycle
    lvlSel = 2'd3;
    #1;
    check("R7 level change", 1'b0, 4'b1000);

    // R10: qualifying clear held without cycDone
    @(negedge clk);
    cycHost = 1'b1; cycRegion = 2'b01; cycOffset = 13'd1; cycWrite = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 no cycDone", 1'b0, 4'b1000);
    cycRegion = 2'b11;

    // Set command too, then reset with everything set
    runCycle(1'b1, 2'b01, 13'd0, 1'b1, 1'b0);
    check("R2 before reset", 1'b1, 4'b1000);
    rstN = 1'b0;
    #1;
    check("R1 async reset", 1'b0, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    // R1: enable cleared by reset, so a new request stays hidden
    runCycle(1'b0, 2'b01, 13'd1, 1'b1, 1'b0);
    check("R1 enable off after reset", 1'b0, 4'b0000);
    runCycle(1'b1, 2'b00, 13'd1, 1'b1, 1'b1);
    check("R8 re-enable", 1'b0, 4'b1000);

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
    end
  end

endmodule